// File: doc/BRIEF.md
# Microprogram Sequencer

This block steps a microcoded control unit through its control memory. It holds the control address register, which addresses the control memory. It also holds the macro-level program counter. On every clock the next control address comes from one of three places: the current address plus one, the next-address field of the current control word, or the opcode held in the instruction register. A one-bit source select chooses between the next-address field and the opcode. A three-bit condition select then chooses a test on the status flags. When the test is true, the chosen address is loaded; when it is false, the register counts up by one. A conditional branch in the instruction set therefore becomes a conditional jump inside the microcode.

Control memory address 0 holds the fetch step, which advances the program counter and loads the instruction register. The decode step jumps to the opcode. Each execute routine ends with a jump back to address 0, so the shortest instruction takes three cycles. The control memory, the instruction register and the datapath sit outside this block. The control word fields, the flags and the opcode arrive as inputs.

Top module: `mseq_top`

## Requirements
- R1: When `rst` is high at a rising clock edge, `car` and `pc` are both 0 after that edge.
- R2: With condition select 000, `car` becomes `car + 1` modulo 2^CAR_W, so 255 wraps to 0.
- R3: With condition select 001, `car` always loads the source-mux address.
- R4: The source-mux address is `na_field` when `src_sel` is 0. It is `opcode` zero-extended to CAR_W bits when `src_sel` is 1.
- R5: Condition selects 010, 011, 100 and 101 test the carry, overflow, zero and negative flags. `car` loads the source-mux address when the tested flag is 1 and increments when it is 0.
- R6: Condition select 110 loads when carry is 0, and 111 loads when zero is 0. Otherwise `car` increments.
- R7: With `pc_rel` low, `pc_inc` high adds 1 to `pc`. With both low, `pc` holds its value.
- R8: With `pc_rel` high, `pc` adds the 6-bit two's-complement offset {fld_a, fld_b}, with `fld_a` as the upper three bits, sign-extended. This takes priority over `pc_inc`.
- R9: A microprogram with fetch at 0 runs each instruction in turn. The fetch step increments the PC and loads the IR, the decode step jumps to the opcode, and each routine returns to 0. A three-step instruction takes three cycles, and a taken branch-if-zero moves `pc` by its offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| na_field | input | CAR_W | Next-address field of the control word |
| src_sel | input | 1 | 0 selects the next-address field, 1 selects the opcode |
| cond_sel | input | 3 | Load condition select |
| pc_inc | input | 1 | Increment the program counter |
| pc_rel | input | 1 | Add the relative offset to the program counter |
| fld_a | input | FLD_W | Upper half of the relative offset |
| fld_b | input | FLD_W | Lower half of the relative offset |
| opcode | input | OP_W | Opcode from the instruction register |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| car | output | CAR_W | Control address register |
| pc | output | PC_W | Program counter |

## Verification
The bench drives each condition select with its flag both set and clear. If the flag test were inverted or the select decoded wrongly, the design would jump where it should count up, and the expected `car` would be missed at once. It loads address 255 and then counts, to catch a counter that saturates or grows instead of wrapping. It applies a negative offset and sets `pc_inc` and `pc_rel` together; a missing sign extension or a wrong priority would leave `pc` a few steps off. It also runs a short microprogram with a not-taken branch, a taken branch and a self-loop. Any slip in the three-step fetch, decode and execute order would move the loop's PC or land `car` away from 0 on the checked cycles.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  typedef enum logic [2:0] {
    CS_INC = 3'b000,
    CS_JMP = 3'b001,
    CS_C   = 3'b010,
    CS_V   = 3'b011,
    CS_Z   = 3'b100,
    CS_N   = 3'b101,
    CS_NC  = 3'b110,
    CS_NZ  = 3'b111
  } cond_e;

  typedef struct packed {
    logic c;
    logic v;
    logic z;
    logic n;
  } flags_t;
endpackage

// File: rtl/mseq_cond_mux.sv
module mseq_cond_mux
  import mseq_pkg::*;
(
  input  cond_e  sel,
  input  flags_t fl,
  output logic   take
);
  always_comb begin
    unique case (sel)
      CS_INC:  take = 1'b0;
      CS_JMP:  take = 1'b1;
      CS_C:    take = fl.c;
      CS_V:    take = fl.v;
      CS_Z:    take = fl.z;
      CS_N:    take = fl.n;
      CS_NC:   take = ~fl.c;
      CS_NZ:   take = ~fl.z;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/mseq_src_mux.sv
module mseq_src_mux #(
  parameter int CAR_W = 8,
  parameter int OP_W  = 6
) (
  input  logic             src_sel,
  input  logic [CAR_W-1:0] na,
  input  logic [OP_W-1:0]  opcode,
  output logic [CAR_W-1:0] addr
);
  logic [CAR_W-1:0] op_ext;

  generate
    if (OP_W < CAR_W) begin : g_pad
      assign op_ext = {{(CAR_W-OP_W){1'b0}}, opcode};
    end else begin : g_cut
      assign op_ext = opcode[CAR_W-1:0];
    end
  endgenerate

  assign addr = src_sel ? op_ext : na;
endmodule

// File: rtl/mseq_car.sv
module mseq_car #(
  parameter int CAR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [CAR_W-1:0] target,
  output logic [CAR_W-1:0] car
);
  localparam logic [CAR_W-1:0] ONE = CAR_W'(1);

  always_ff @(posedge clk) begin
    if (rst)       car <= '0;
    else if (take) car <= target;
    else           car <= car + ONE;
  end
endmodule

// File: rtl/mseq_pc.sv
module mseq_pc #(
  parameter int PC_W  = 8,
  parameter int FLD_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             rel,
  input  logic [FLD_W-1:0] fa,
  input  logic [FLD_W-1:0] fb,
  output logic [PC_W-1:0]  pc
);
  localparam int OFF_W = 2 * FLD_W;
  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  logic [OFF_W-1:0] off;
  logic [PC_W-1:0]  off_ext;

  assign off = {fa, fb};

  generate
    if (OFF_W < PC_W) begin : g_sext
      assign off_ext = {{(PC_W-OFF_W){off[OFF_W-1]}}, off};
    end else begin : g_trunc
      assign off_ext = off[PC_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)      pc <= '0;
    else if (rel) pc <= pc + off_ext;
    else if (inc) pc <= pc + ONE;
  end
endmodule

// File: rtl/mseq_top.sv
module mseq_top
  import mseq_pkg::*;
#(
  parameter int CAR_W = 8,
  parameter int OP_W  = 6,
  parameter int PC_W  = 8,
  parameter int FLD_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CAR_W-1:0] na_field,
  input  logic             src_sel,
  input  logic [2:0]       cond_sel,
  input  logic             pc_inc,
  input  logic             pc_rel,
  input  logic [FLD_W-1:0] fld_a,
  input  logic [FLD_W-1:0] fld_b,
  input  logic [OP_W-1:0]  opcode,
  input  logic             flag_c,
  input  logic             flag_v,
  input  logic             flag_z,
  input  logic             flag_n,
  output logic [CAR_W-1:0] car,
  output logic [PC_W-1:0]  pc
);
  flags_t           fl;
  logic             take;
  logic [CAR_W-1:0] target;

  assign fl = '{c: flag_c, v: flag_v, z: flag_z, n: flag_n};

  mseq_cond_mux u_cond (
    .sel  (cond_e'(cond_sel)),
    .fl   (fl),
    .take (take)
  );

  mseq_src_mux #(.CAR_W(CAR_W), .OP_W(OP_W)) u_src (
    .src_sel (src_sel),
    .na      (na_field),
    .opcode  (opcode),
    .addr    (target)
  );

  mseq_car #(.CAR_W(CAR_W)) u_car (
    .clk    (clk),
    .rst    (rst),
    .take   (take),
    .target (target),
    .car    (car)
  );

  mseq_pc #(.PC_W(PC_W), .FLD_W(FLD_W)) u_pc (
    .clk (clk),
    .rst (rst),
    .inc (pc_inc),
    .rel (pc_rel),
    .fa  (fld_a),
    .fb  (fld_b),
    .pc  (pc)
  );
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk #(
  parameter int CAR_W = 8,
  parameter int OP_W  = 6,
  parameter int PC_W  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [CAR_W-1:0] na_field,
  input logic             src_sel,
  input logic [2:0]       cond_sel,
  input logic             pc_inc,
  input logic             pc_rel,
  input logic [OP_W-1:0]  opcode,
  input logic             flag_z,
  input logic [CAR_W-1:0] car,
  input logic [PC_W-1:0]  pc
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (car == '0 && pc == '0)); // R1

  AST_PLAIN_INC: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 3'b000) |=> (car == $past(car) + CAR_W'(1))); // R2

  AST_LOAD_NA: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 3'b001 && !src_sel) |=> (car == $past(na_field))); // R3

  AST_LOAD_OPCODE: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 3'b001 && src_sel) |=> (car == CAR_W'($past(opcode)))); // R4

  AST_ZERO_FALSE_INC: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 3'b100 && !flag_z) |=> (car == $past(car) + CAR_W'(1))); // R5

  AST_NZ_FALSE_INC: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 3'b111 && flag_z) |=> (car == $past(car) + CAR_W'(1))); // R6

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!pc_inc && !pc_rel) |=> $stable(pc)); // R7
endmodule

bind mseq_top mseq_chk #(.CAR_W(CAR_W), .OP_W(OP_W), .PC_W(PC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .na_field (na_field),
  .src_sel  (src_sel),
  .cond_sel (cond_sel),
  .pc_inc   (pc_inc),
  .pc_rel   (pc_rel),
  .opcode   (opcode),
  .flag_z   (flag_z),
  .car      (car),
  .pc       (pc)
);

// File: tb/mseq_top_tb.sv
module mseq_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] na_field = '0;
  logic       src_sel = 1'b0;
  logic [2:0] cond_sel = '0;
  logic       pc_inc = 1'b0;
  logic       pc_rel = 1'b0;
  logic [2:0] fld_a = '0;
  logic [2:0] fld_b = '0;
  logic [5:0] opcode = '0;
  logic       flag_c = 1'b0;
  logic       flag_v = 1'b0;
  logic       flag_z = 1'b0;
  logic       flag_n = 1'b0;
  logic [7:0] car;
  logic [7:0] pc;

  always #4 clk = ~clk;

  mseq_top u_dut (
    .clk(clk), .rst(rst), .na_field(na_field), .src_sel(src_sel),
    .cond_sel(cond_sel), .pc_inc(pc_inc), .pc_rel(pc_rel),
    .fld_a(fld_a), .fld_b(fld_b), .opcode(opcode),
    .flag_c(flag_c), .flag_v(flag_v), .flag_z(flag_z), .flag_n(flag_n),
    .car(car), .pc(pc)
  );

  typedef struct {
    logic [7:0] car;
    logic [7:0] pc;
    string      req;
  } exp_t;

  exp_t       sb[$];
  int         n_chk = 0;
  int         n_fail = 0;
  logic [7:0] m_car = '0;
  logic [7:0] m_pc = '0;
  logic [15:0] ir = '0;

  function automatic bit cond_true(input logic [2:0] cs);
    case (cs)
      3'b000: return 1'b0;
      3'b001: return 1'b1;
      3'b010: return flag_c;
      3'b011: return flag_v;
      3'b100: return flag_z;
      3'b101: return flag_n;
      3'b110: return !flag_c;
      default: return !flag_z;
    endcase
  endfunction

  // Driver: model the edge from the current inputs and queue the result.
  task automatic tick(input string req);
    exp_t e;
    logic [7:0] tgt;
    if (rst) begin
      m_car = '0;
      m_pc  = '0;
    end else begin
      tgt   = src_sel ? {2'b00, opcode} : na_field;
      m_car = cond_true(cond_sel) ? tgt : m_car + 8'd1;
      if (pc_rel)      m_pc = m_pc + {{2{fld_a[2]}}, fld_a, fld_b};
      else if (pc_inc) m_pc = m_pc + 8'd1;
    end
    e.car = m_car;
    e.pc  = m_pc;
    e.req = req;
    @(posedge clk);
    #1;
    sb.push_back(e);
  endtask

  // Monitor: compare queued expectations half a cycle later.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (car !== e.car || pc !== e.pc) begin
        n_fail++;
        $display("FAIL %s car=%0d pc=%0d expected car=%0d pc=%0d",
                 e.req, car, pc, e.car, e.pc);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cw(input logic [7:0] na, input logic s, input logic [2:0] cs);
    na_field = na;
    src_sel  = s;
    cond_sel = cs;
  endtask

  // Control ROM: {il, pl, pi, cond[2:0], src, na[7:0]}
  function automatic logic [14:0] rom(input logic [7:0] a);
    case (a)
      8'd0:  return {1'b1, 1'b0, 1'b1, 3'b000, 1'b0, 8'd0};
      8'd1:  return {1'b0, 1'b0, 1'b0, 3'b001, 1'b1, 8'd0};
      8'd9:  return {1'b0, 1'b1, 1'b0, 3'b001, 1'b0, 8'd0};
      8'd10: return {1'b0, 1'b0, 1'b0, 3'b100, 1'b0, 8'd9};
      8'd12: return {1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 8'd0};
      default: return {1'b0, 1'b0, 1'b0, 3'b001, 1'b0, 8'd0};
    endcase
  endfunction

  // Program memory: {op[5:0], a[2:0], b[2:0], z, 3'b0}
  function automatic logic [15:0] prog(input logic [7:0] a);
    case (a)
      8'd1: return {6'd10, 3'd0, 3'd2, 1'b0, 3'b0};
      8'd2: return {6'd12, 3'd0, 3'd0, 1'b0, 3'b0};
      8'd3: return {6'd10, 3'd0, 3'd2, 1'b1, 3'b0};
      8'd6: return {6'd9,  3'd7, 3'd7, 1'b0, 3'b0};
      default: return {6'd8, 3'd0, 3'd0, 1'b0, 3'b0};
    endcase
  endfunction

  task automatic rom_cycle();
    logic [14:0] w;
    logic [15:0] nir;
    w = rom(m_car);
    opcode = ir[15:10];
    fld_a  = ir[9:7];
    fld_b  = ir[6:4];
    flag_z = ir[3];
    flag_c = 1'b0; flag_v = 1'b0; flag_n = 1'b0;
    pc_rel = w[13];
    pc_inc = w[12];
    cw(w[7:0], w[8], w[11:9]);
    nir = w[14] ? prog(m_pc) : ir;
    tick("R9 microprogram");
    ir = nir;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    rst = 1'b1;
    tick("R1 reset");
    tick("R1 reset");
    rst = 1'b0;

    // R2: plain increment, and wrap at 255
    cw(8'd0, 1'b0, 3'b000);
    tick("R2 inc");
    tick("R2 inc");
    cw(8'd255, 1'b0, 3'b001);
    tick("R3 load na 255");
    cw(8'd0, 1'b0, 3'b000);
    tick("R2 wrap 255->0");

    // R3 and R4: source mux
    cw(8'd77, 1'b0, 3'b001);
    opcode = 6'd45;
    tick("R4 src0 picks na");
    cw(8'd77, 1'b1, 3'b001);
    tick("R4 src1 picks opcode");
    opcode = 6'd63;
    tick("R4 opcode zero-extended");

    // R5: flag conditions, true and false
    for (int cs = 2; cs < 6; cs++) begin
      cw(8'd40 + 8'(cs), 1'b0, 3'(cs));
      {flag_c, flag_v, flag_z, flag_n} = 4'b0000;
      tick("R5 flag clear increments");
      case (cs)
        2: flag_c = 1'b1;
        3: flag_v = 1'b1;
        4: flag_z = 1'b1;
        default: flag_n = 1'b1;
      endcase
      tick("R5 flag set loads");
      {flag_c, flag_v, flag_z, flag_n} = 4'b1111;
      flag_c = (cs == 2) ? 1'b0 : 1'b1;
      flag_v = (cs == 3) ? 1'b0 : 1'b1;
      flag_z = (cs == 4) ? 1'b0 : 1'b1;
      flag_n = (cs == 5) ? 1'b0 : 1'b1;
      tick("R5 other flags ignored");
    end

    // R6: inverted conditions
    {flag_c, flag_v, flag_z, flag_n} = 4'b0000;
    cw(8'd90, 1'b0, 3'b110);
    tick("R6 not-carry loads");
    flag_c = 1'b1;
    tick("R6 not-carry increments");
    cw(8'd100, 1'b0, 3'b111);
    flag_z = 1'b1;
    tick("R6 not-zero increments");
    flag_z = 1'b0;
    tick("R6 not-zero loads");

    // R7: pc increment and hold
    cw(8'd0, 1'b0, 3'b000);
    pc_inc = 1'b1;
    tick("R7 pc inc");
    tick("R7 pc inc");
    pc_inc = 1'b0;
    tick("R7 pc hold");

    // R8: relative offset, sign and priority
    fld_a = 3'd0; fld_b = 3'd5; pc_rel = 1'b1;
    tick("R8 pc +5");
    fld_a = 3'd7; fld_b = 3'd6; pc_inc = 1'b1;
    tick("R8 pc -2 beats inc");
    fld_a = 3'd4; fld_b = 3'd0; pc_inc = 1'b0;
    tick("R8 pc -32");
    pc_rel = 1'b0;

    // R1: reset in mid-run
    rst = 1'b1;
    cw(8'd33, 1'b0, 3'b001);
    pc_inc = 1'b1;
    tick("R1 reset wins");
    rst = 1'b0;
    pc_inc = 1'b0;

    // R9: microprogram run from reset
    rst = 1'b1;
    tick("R1 reset before program");
    rst = 1'b0;
    ir = '0;
    for (int i = 0; i < 15; i++) rom_cycle();
    chk("R9 car back at fetch", car, 8'd0);
    chk("R9 pc after taken branch", pc, 8'd6);
    for (int i = 0; i < 3; i++) rom_cycle();
    chk("R9 self-loop car", car, 8'd0);
    chk("R9 self-loop pc", pc, 8'd6);

    @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule